// File: doc/BRIEF.md
# Floppy Data-Rate and Power Control

This block holds the host-writable data-rate/power byte of a floppy disk controller and the logic around it. It decodes host writes at offset 4 of the controller window. From those writes it keeps the write-precompensation select and a data-rate code, and it sets a manual low-power state that drops the controller clock enable and the data-separator enable. A bit in the same byte raises a self-clearing software reset, which becomes a fixed-length pulse.

A second write-only register at offset 7 carries only a 2-bit rate field. The effective rate is whichever of the two registers the host wrote last. The controller core reset is the software reset pulse combined with the active-low reset bit of the digital output register. The block watches host accesses to the main status register (read at offset 4) and the data register (offset 5) so that it can leave low power. A compare of the current track against a configurable starting track tells the write path when precompensation applies.

Top module: `fdc_rate_pwr_ctl`

## Requirements
- R1: After hardware reset the outputs are as follows: rate_code = 2'b10 (250 kbps), precomp_sel = 0, low_power = 0, clk_en = dsep_en = 1 and sw_rst_pulse = 0. core_reset follows only dor_reset_n.
- R2: A write at offset 4 loads byte bits 1:0 into rate_code and bits 4:2 into precomp_sel, visible the cycle after the write. Bit 5 has no effect.
- R3: A write at offset 7 loads byte bits 1:0 into rate_code the cycle after the write. precomp_sel and low_power are left unchanged.
- R4: rate_code always reflects the most recent write, whether it went to offset 4 or offset 7.
- R5: rate_kbps decodes rate_code as 00=500, 01=300, 10=250 and 11=1000.
- R6: An offset-4 write with bit 6 = 1 and bit 7 = 0 sets low_power the next cycle. While low_power is 1, clk_en and dsep_en are 0.
- R7: low_power is cleared the next cycle by any of these: a read at offset 4, a read or write at offset 5, an offset-4 write with bit 7 = 1, or dor_reset_n = 0. A clear and a set in the same cycle leave low_power at 0.
- R8: An offset-4 write with bit 7 = 1 drives sw_rst_pulse high for exactly 4 cycles, starting the cycle after the write. A new such write during the pulse restarts the 4-cycle count. The bit is never retained.
- R9: Neither the software reset pulse nor dor_reset_n changes rate_code or precomp_sel.
- R10: core_reset = sw_rst_pulse OR (dor_reset_n == 0), combinationally.
- R11: precomp_active is 1 exactly when cur_track >= start_track.
- R12: Accesses at offsets other than 4, 5 and 7, and reads at offset 7, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 3 | Register offset within the controller window |
| host_wdata | input | 8 | Host write data |
| dor_reset_n | input | 1 | Reset bit of the digital output register, active low |
| start_track | input | 8 | First track to receive precompensation |
| cur_track | input | 8 | Track currently being written |
| rate_code | output | 2 | Effective data-rate code |
| rate_kbps | output | 11 | Effective data rate in kbps |
| precomp_sel | output | 3 | Write precompensation select |
| precomp_active | output | 1 | Current track is at or past the starting track |
| low_power | output | 1 | Manual low-power state |
| clk_en | output | 1 | Controller clock enable |
| dsep_en | output | 1 | Data separator enable |
| sw_rst_pulse | output | 1 | Software reset pulse |
| core_reset | output | 1 | Combined controller core reset, active high |

## Verification
The assertions assume one host access per cycle: host_wr and host_rd are never high together, and each strobe lasts one cycle. The checks on the offset-7 write and on rate holding therefore assume that no offset-4 write happens in the same cycle. The bench drives every access as a single-cycle strobe on the falling edge and never overlaps a read with a write. It changes dor_reset_n only between accesses, or deliberately alongside a low-power request so that the priority of the clear can be seen.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;

  localparam int RATE_W  = 2;
  localparam int PC_W    = 3;
  localparam int KBPS_W  = 11;

  // byte positions decoded by the power / reset logic
  localparam int BIT_LOWPWR = 6;
  localparam int BIT_SWRST  = 7;

  typedef enum logic [RATE_W-1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rate_e;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    rate_e           rate;
  } rate_fields_t;

  localparam logic [7:0] HW_DEFAULT_BYTE = 8'h02;

  function automatic rate_fields_t unpack_fields(input logic [4:0] lo);
    rate_fields_t f;
    f.rate = rate_e'(lo[1:0]);
    f.pc   = lo[4:2];
    return f;
  endfunction

  function automatic logic [KBPS_W-1:0] rate_to_kbps(input rate_e r);
    logic [KBPS_W-1:0] k;
    case (r)
      RATE_500K: k = KBPS_W'(500);
      RATE_300K: k = KBPS_W'(300);
      RATE_250K: k = KBPS_W'(250);
      default:   k = KBPS_W'(1000);
    endcase
    return k;
  endfunction

  function automatic logic track_reached(input logic [15:0] cur, input logic [15:0] first);
    return cur >= first;
  endfunction

endpackage

// File: rtl/fdc_host_decode.sv
module fdc_host_decode #(
  parameter int ADDR_W   = 3,
  parameter int RATE_OFS = 4,
  parameter int CCR_OFS  = 7,
  parameter int DATA_OFS = 5,
  parameter int STAT_OFS = 4
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              rate_wr,
  output logic              ccr_wr,
  output logic              wake_access
);
  localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'(RATE_OFS);
  localparam logic [ADDR_W-1:0] A_CCR  = ADDR_W'(CCR_OFS);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  logic stat_rd;
  logic data_acc;

  always_comb begin
    rate_wr     = host_wr && (host_addr == A_RATE);
    ccr_wr      = host_wr && (host_addr == A_CCR);
    stat_rd     = host_rd && (host_addr == A_STAT);
    data_acc    = (host_wr || host_rd) && (host_addr == A_DATA);
    wake_access = stat_rd || data_acc;
  end
endmodule

// File: rtl/fdc_rate_regs.sv
module fdc_rate_regs
  import fdc_rate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rate_wr,
  input  logic            ccr_wr,
  input  logic [4:0]      wdata_lo,
  output rate_e           rate_q,
  output logic [PC_W-1:0] pc_q
);
  rate_fields_t dflt;
  rate_fields_t wf;

  always_comb begin
    dflt = unpack_fields(HW_DEFAULT_BYTE[4:0]);
    wf   = unpack_fields(wdata_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= dflt.rate;
      pc_q   <= dflt.pc;
    end else if (rate_wr) begin
      rate_q <= wf.rate;
      pc_q   <= wf.pc;
    end else if (ccr_wr) begin
      rate_q <= wf.rate;
    end
  end
endmodule

// File: rtl/fdc_pwr_rst.sv
module fdc_pwr_rst #(
  parameter int SWRST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_wr,
  input  logic lowpwr_bit,
  input  logic swrst_bit,
  input  logic wake_access,
  input  logic dor_reset_n,
  output logic low_power,
  output logic sw_rst_pulse,
  output logic lp_enter_evt,
  output logic lp_exit_evt,
  output logic swrst_req_evt
);
  localparam int CNT_W = $clog2(SWRST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SWRST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    swrst_req_evt = rate_wr && swrst_bit;
    lp_enter_evt  = rate_wr && lowpwr_bit;
    lp_exit_evt   = swrst_req_evt || wake_access || !dor_reset_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (swrst_req_evt)     cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign sw_rst_pulse = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_power <= 1'b0;
    else if (lp_exit_evt)  low_power <= 1'b0;
    else if (lp_enter_evt) low_power <= 1'b1;
  end
endmodule

// File: rtl/fdc_rate_pwr_ctl.sv
module fdc_rate_pwr_ctl
  import fdc_rate_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int TRK_W        = 8,
  parameter int RATE_OFS     = 4,
  parameter int CCR_OFS      = 7,
  parameter int DATA_OFS     = 5,
  parameter int STAT_OFS     = 4,
  parameter int SWRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              dor_reset_n,
  input  logic [TRK_W-1:0]  start_track,
  input  logic [TRK_W-1:0]  cur_track,
  output logic [1:0]        rate_code,
  output logic [10:0]       rate_kbps,
  output logic [2:0]        precomp_sel,
  output logic              precomp_active,
  output logic              low_power,
  output logic              clk_en,
  output logic              dsep_en,
  output logic              sw_rst_pulse,
  output logic              core_reset
);
  // named internal events, observed by the bound checker
  logic  rate_wr_evt;
  logic  ccr_wr_evt;
  logic  wake_evt;
  logic  lp_enter_evt;
  logic  lp_exit_evt;
  logic  swrst_req_evt;
  rate_e rate_q;
  logic  wdata_rsvd_unused;

  assign wdata_rsvd_unused = host_wdata[5];

  fdc_host_decode #(
    .ADDR_W(ADDR_W), .RATE_OFS(RATE_OFS), .CCR_OFS(CCR_OFS),
    .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
  ) dec_i (
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .rate_wr     (rate_wr_evt),
    .ccr_wr      (ccr_wr_evt),
    .wake_access (wake_evt)
  );

  fdc_rate_regs regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_wr  (rate_wr_evt),
    .ccr_wr   (ccr_wr_evt),
    .wdata_lo (host_wdata[4:0]),
    .rate_q   (rate_q),
    .pc_q     (precomp_sel)
  );

  fdc_pwr_rst #(.SWRST_CYCLES(SWRST_CYCLES)) pwr_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rate_wr       (rate_wr_evt),
    .lowpwr_bit    (host_wdata[BIT_LOWPWR]),
    .swrst_bit     (host_wdata[BIT_SWRST]),
    .wake_access   (wake_evt),
    .dor_reset_n   (dor_reset_n),
    .low_power     (low_power),
    .sw_rst_pulse  (sw_rst_pulse),
    .lp_enter_evt  (lp_enter_evt),
    .lp_exit_evt   (lp_exit_evt),
    .swrst_req_evt (swrst_req_evt)
  );

  always_comb begin
    rate_code      = rate_q;
    rate_kbps      = rate_to_kbps(rate_q);
    clk_en         = !low_power;
    dsep_en        = !low_power;
    core_reset     = sw_rst_pulse || !dor_reset_n;
    precomp_active = track_reached(16'(cur_track), 16'(start_track));
  end
endmodule

// File: rtl/fdc_rate_pwr_ctl_chk.sv
module fdc_rate_pwr_ctl_chk #(
  parameter int SWRST_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] wdata_lo,
  input logic       dor_reset_n,
  input logic       rate_wr_evt,
  input logic       ccr_wr_evt,
  input logic       lp_enter_evt,
  input logic       lp_exit_evt,
  input logic       swrst_req_evt,
  input logic [1:0] rate_code,
  input logic [2:0] precomp_sel,
  input logic       low_power,
  input logic       clk_en,
  input logic       dsep_en,
  input logic       sw_rst_pulse,
  input logic       core_reset
);
  localparam int RUN_W = $clog2(SWRST_CYCLES + 2) + 1;
  logic [RUN_W-1:0] run_cnt;

  // counts pulse cycles since the latest software reset request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_cnt <= '0;
    else if (swrst_req_evt) run_cnt <= RUN_W'(1);
    else if (sw_rst_pulse)  run_cnt <= run_cnt + 1'b1;
    else                    run_cnt <= '0;
  end

  assert_rate_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr_evt |=> (rate_code == $past(wdata_lo[1:0])) && (precomp_sel == $past(wdata_lo[4:2])));

  assert_ccr_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr_evt && !rate_wr_evt) |=> (rate_code == $past(wdata_lo[1:0])) && $stable(precomp_sel));

  assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_wr_evt && !ccr_wr_evt) |=> $stable(rate_code) && $stable(precomp_sel));

  assert_lp_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_enter_evt && !lp_exit_evt) |=> low_power);

  assert_lp_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (!clk_en && !dsep_en));

  assert_lp_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit_evt |=> !low_power);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req_evt |=> sw_rst_pulse);

  assert_pulse_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_pulse |-> ((run_cnt >= RUN_W'(1)) && (run_cnt <= RUN_W'(SWRST_CYCLES))));

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_rst_pulse) |-> (run_cnt == RUN_W'(SWRST_CYCLES + 1)));

  assert_core_rst_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst_pulse || !dor_reset_n) |-> core_reset);

  assert_core_rst_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst_pulse && dor_reset_n) |-> !core_reset);
endmodule

bind fdc_rate_pwr_ctl fdc_rate_pwr_ctl_chk #(.SWRST_CYCLES(SWRST_CYCLES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wdata_lo      (host_wdata[4:0]),
  .dor_reset_n   (dor_reset_n),
  .rate_wr_evt   (rate_wr_evt),
  .ccr_wr_evt    (ccr_wr_evt),
  .lp_enter_evt  (lp_enter_evt),
  .lp_exit_evt   (lp_exit_evt),
  .swrst_req_evt (swrst_req_evt),
  .rate_code     (rate_code),
  .precomp_sel   (precomp_sel),
  .low_power     (low_power),
  .clk_en        (clk_en),
  .dsep_en       (dsep_en),
  .sw_rst_pulse  (sw_rst_pulse),
  .core_reset    (core_reset)
);

// File: tb/fdc_rate_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module fdc_rate_pwr_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        dor_reset_n = 1'b1;
  logic [7:0]  start_track = '0;
  logic [7:0]  cur_track = '0;
  logic [1:0]  rate_code;
  logic [10:0] rate_kbps;
  logic [2:0]  precomp_sel;
  logic        precomp_active, low_power, clk_en, dsep_en, sw_rst_pulse, core_reset;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fdc_rate_pwr_ctl dut_i (.*);

  // {wr, rd, addr[3], data[8], exp_rate[2], exp_pc[3], exp_lp}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd4, 8'h05, 2'd1, 3'd1, 1'b0},  // R2
    {1'b1, 1'b0, 3'd7, 8'h03, 2'd3, 3'd1, 1'b0},  // R3 R4
    {1'b1, 1'b0, 3'd4, 8'h2C, 2'd0, 3'd3, 1'b0},  // R2 bit5 ignored
    {1'b1, 1'b0, 3'd4, 8'h4E, 2'd2, 3'd3, 1'b1},  // R6
    {1'b1, 1'b0, 3'd7, 8'h01, 2'd1, 3'd3, 1'b1},  // R3 keeps lp
    {1'b0, 1'b1, 3'd6, 8'h00, 2'd1, 3'd3, 1'b1},  // R12
    {1'b1, 1'b0, 3'd3, 8'hFF, 2'd1, 3'd3, 1'b1},  // R12
    {1'b0, 1'b1, 3'd4, 8'h00, 2'd1, 3'd3, 1'b0},  // R7 status read
    {1'b1, 1'b0, 3'd4, 8'h50, 2'd0, 3'd4, 1'b1},  // R6
    {1'b0, 1'b1, 3'd5, 8'h00, 2'd0, 3'd4, 1'b0},  // R7 data read
    {1'b1, 1'b0, 3'd4, 8'h41, 2'd1, 3'd0, 1'b1},  // R6
    {1'b1, 1'b0, 3'd5, 8'h00, 2'd1, 3'd0, 1'b0},  // R7 data write
    {1'b1, 1'b0, 3'd4, 8'h42, 2'd2, 3'd0, 1'b1},  // R6
    {1'b0, 1'b1, 3'd7, 8'h00, 2'd2, 3'd0, 1'b1}   // R12 read at 7
  };

  function automatic int exp_kbps(input logic [1:0] c);
    int tbl [4] = '{500, 300, 250, 1000};
    return tbl[c];
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drives one single-cycle access at a falling edge; returns at the next falling edge
  task automatic access(input bit wr, input bit rd, input logic [2:0] a, input logic [7:0] d);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
  endtask

  task automatic check_state(input string req, input int r, input int pc, input int lp);
    check(req, "rate_code", rate_code, r);
    check(req, "precomp_sel", precomp_sel, pc);
    check(req, "low_power", low_power, lp);
    check(req, "clk_en", clk_en, lp ? 0 : 1);
    check(req, "dsep_en", dsep_en, lp ? 0 : 1);
    check("R5", "rate_kbps", rate_kbps, exp_kbps(2'(r)));
  endtask

  task automatic check_reset_state();
    check_state("R1", 2, 0, 0);
    check("R1", "sw_rst_pulse", sw_rst_pulse, 0);
    check("R1", "core_reset", core_reset, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // vector table: R2 R3 R4 R5 R6 R7 R12
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][18], VEC[i][17], VEC[i][16:14], VEC[i][13:6]);
      check_state($sformatf("vec%0d", i), VEC[i][5:4], VEC[i][3:1], VEC[i][0]);
    end

    // R8 R7 R9 R10: software reset with low-power request in the same byte
    access(1, 0, 3'd4, 8'hCE);
    check_state("R7", 2, 3, 0);
    for (int k = 0; k < 4; k++) begin
      check("R8", "sw_rst_pulse high", sw_rst_pulse, 1);
      check("R10", "core_reset during pulse", core_reset, 1);
      check_state("R9", 2, 3, 0);
      @(negedge clk);
    end
    check("R8", "sw_rst_pulse end", sw_rst_pulse, 0);
    check("R10", "core_reset after pulse", core_reset, 0);

    // R8 retrigger: second request two cycles in extends to 6 cycles total
    access(1, 0, 3'd4, 8'h80);
    check("R8", "retrig first", sw_rst_pulse, 1);
    @(negedge clk);
    access(1, 0, 3'd4, 8'h80);
    for (int k = 0; k < 4; k++) begin
      check("R8", "retrig high", sw_rst_pulse, 1);
      @(negedge clk);
    end
    check("R8", "retrig end", sw_rst_pulse, 0);

    // R10 R7 R9: digital output reset bit
    access(1, 0, 3'd4, 8'h43);
    check_state("R6", 3, 0, 1);
    dor_reset_n = 1'b0;
    #1;
    check("R10", "core_reset from dor", core_reset, 1);
    check("R10", "pulse idle", sw_rst_pulse, 0);
    @(negedge clk);
    check_state("R9", 3, 0, 0);
    access(1, 0, 3'd4, 8'h47);   // entry while dor reset held: exit wins (R7)
    check_state("R7", 3, 1, 0);
    dor_reset_n = 1'b1;
    #1;
    check("R10", "core_reset released", core_reset, 0);
    @(negedge clk);

    // R5 R4: each rate code through offset 7
    for (int c = 0; c < 4; c++) begin
      access(1, 0, 3'd7, 8'(c));
      check("R4", "rate via ccr", rate_code, c);
      check("R5", "kbps", rate_kbps, exp_kbps(2'(c)));
    end

    // R11: precompensation start track
    start_track = 8'd10;
    cur_track = 8'd9;   #1; check("R11", "below start", precomp_active, 0);
    cur_track = 8'd10;  #1; check("R11", "at start", precomp_active, 1);
    cur_track = 8'd200; #1; check("R11", "above start", precomp_active, 1);
    start_track = 8'd0; cur_track = 8'd0; #1; check("R11", "track 0", precomp_active, 1);

    // R1: hardware reset mid-run restores defaults
    @(negedge clk);
    access(1, 0, 3'd4, 8'h5D);
    check_state("R2", 1, 7, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule